// File: doc/BRIEF.md
# E1 Receive Loss-of-Signal Monitor

This block sits behind the line receiver of a 2.048 Mbit/s E1 port. It watches the two unipolar receive rails, one per pulse polarity, once per bit period. A bit period counts as a one when either rail carries a pulse. It counts as a zero when neither rail does. A long unbroken run of zeros means the line has gone quiet, and the block raises a loss-of-signal alarm.

Once the alarm is raised, it is not released by one stray pulse. A recovery window opens on the first one seen after the alarm. The alarm drops only when enough ones arrive inside a window two frames long. If the window expires first, its counts are discarded and the next one opens a new window. While the alarm is high, both rail outputs toward the decoder are held high. While it is low, the rails pass straight through.

The block runs on a fast system clock. A one-cycle bit enable marks each 2.048 MHz bit period, and only cycles with the enable high are counted.

Top module: `e1_los_monitor`

## Requirements
- R1: After reset `los_o` is low.
- R2: A zero is an enabled cycle with both rail inputs low. `los_o` rises on the clock edge that samples the 128th consecutive zero, and not on any earlier edge.
- R3: While `los_o` is low, any one resets the zero run. So 127 zeros, a one, then 127 zeros leave `los_o` low. The run count saturates, so an arbitrarily long silence keeps `los_o` high.
- R4: While `los_o` is high, `rail_pos_o` and `rail_neg_o` are both 1, whatever the inputs.
- R5: While `los_o` is low, `rail_pos_o` equals `rail_pos_in` and `rail_neg_o` equals `rail_neg_in` in the same cycle.
- R6: After `los_o` rises, the first one opens a recovery window of 512 bit periods that includes that one. `los_o` falls on the edge that samples the 64th one counted in the window, including when that one is the window's 512th bit.
- R7: If a window reaches its 512th bit with fewer than 64 ones, it closes and its counts are discarded. The next one opens a fresh window.
- R8: `los_o` changes only on edges where `bit_en` is high. Cycles with `bit_en` low count neither as zeros nor as ones.
- R9: When `los_o` falls, the zero run restarts from zero, so 127 further zeros do not raise it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe marking each received bit period |
| rail_pos_in | input | 1 | Positive-pulse receive rail |
| rail_neg_in | input | 1 | Negative-pulse receive rail |
| los_o | output | 1 | Loss-of-signal alarm |
| rail_pos_o | output | 1 | Positive rail toward the decoder, forced high during the alarm |
| rail_neg_o | output | 1 | Negative rail toward the decoder, forced high during the alarm |

## Verification
The hardest situations to reach from the ports are the edges of the recovery window. One is a 64th one that lands exactly on the 512th bit, which must clear the alarm. The other is a window that closes one bit short, whose counts must not leak into the next window. The stimulus builds both cases by placing ones at exact offsets from the opening one: a long quiet stretch followed by a dense burst that ends on the boundary bit, and a sparse window that falls one short. Disabled cycles that carry pulses or silence are placed where counting them would visibly change when the alarm rises or falls. A behavioural model compares all outputs on every clock.

// File: rtl/e1_los_pkg.sv
`timescale 1ns/1ps
package e1_los_pkg;
   typedef enum logic {
      WIN_IDLE = 1'b0,
      WIN_OPEN = 1'b1
   } win_state_e;

   typedef struct packed {
      logic pos;
      logic neg;
   } rail_pair_t;

   localparam int unsigned RAIL_COUNT = 2;

   function automatic logic is_mark(input rail_pair_t r);
      return r.pos | r.neg;
   endfunction
endpackage

// File: rtl/e1_los_zero_run.sv
`timescale 1ns/1ps
module e1_los_zero_run #(
   parameter int unsigned SET_ZEROS = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic mark,
   input  logic hold,
   output logic run_hit
);
   localparam int unsigned RUN_W = $clog2(SET_ZEROS + 1);
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(SET_ZEROS);
   localparam logic [RUN_W-1:0] RUN_ARM = RUN_W'(SET_ZEROS - 1);

   generate
      if (SET_ZEROS < 2) begin : g_bad_set
         $error("SET_ZEROS must be at least 2");
      end
   endgenerate

   logic [RUN_W-1:0] run_q;
   logic [RUN_W-1:0] run_d;

   always_comb begin
      run_d = run_q;
      if (hold) begin
         run_d = '0;
      end else if (step) begin
         if (mark) begin
            run_d = '0;
         end else if (run_q != RUN_MAX) begin
            run_d = run_q + RUN_W'(1);
         end
      end
   end

   assign run_hit = step & ~hold & ~mark & (run_q >= RUN_ARM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else begin
         run_q <= run_d;
      end
   end
endmodule

// File: rtl/e1_los_density_window.sv
`timescale 1ns/1ps
module e1_los_density_window
   import e1_los_pkg::*;
#(
   parameter int unsigned CLEAR_ONES  = 64,
   parameter int unsigned WINDOW_BITS = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic mark,
   input  logic arm,
   output logic win_clear
);
   localparam int unsigned BIT_W = $clog2(WINDOW_BITS + 1);
   localparam int unsigned ONE_W = $clog2(CLEAR_ONES + 1);
   localparam logic [BIT_W-1:0] BIT_LIMIT = BIT_W'(WINDOW_BITS);
   localparam logic [ONE_W-1:0] ONE_LIMIT = ONE_W'(CLEAR_ONES);
   localparam logic SINGLE_ONE = (CLEAR_ONES == 1);

   generate
      if (CLEAR_ONES < 1) begin : g_bad_ones
         $error("CLEAR_ONES must be at least 1");
      end
      if (WINDOW_BITS < CLEAR_ONES) begin : g_bad_window
         $error("WINDOW_BITS must not be smaller than CLEAR_ONES");
      end
   endgenerate

   win_state_e       state_q;
   logic [BIT_W-1:0] bits_q;
   logic [ONE_W-1:0] ones_q;
   logic [BIT_W-1:0] bits_nx;
   logic [ONE_W-1:0] ones_nx;
   logic             expire;

   assign bits_nx = bits_q + BIT_W'(1);
   assign ones_nx = ones_q + ONE_W'(mark);
   assign expire  = (bits_nx >= BIT_LIMIT);

   always_comb begin
      win_clear = 1'b0;
      if (step && arm) begin
         if (state_q == WIN_OPEN) begin
            win_clear = (ones_nx >= ONE_LIMIT);
         end else begin
            win_clear = mark & SINGLE_ONE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WIN_IDLE;
         bits_q  <= '0;
         ones_q  <= '0;
      end else if (!arm) begin
         state_q <= WIN_IDLE;
         bits_q  <= '0;
         ones_q  <= '0;
      end else if (step) begin
         if (state_q == WIN_IDLE) begin
            if (mark && !win_clear) begin
               state_q <= WIN_OPEN;
               bits_q  <= BIT_W'(1);
               ones_q  <= ONE_W'(1);
            end
         end else if (win_clear || expire) begin
            state_q <= WIN_IDLE;
            bits_q  <= '0;
            ones_q  <= '0;
         end else begin
            bits_q <= bits_nx;
            ones_q <= ones_nx;
         end
      end
   end
endmodule

// File: rtl/e1_los_rail_gate.sv
`timescale 1ns/1ps
module e1_los_rail_gate #(
   parameter int unsigned N_RAILS = 2
) (
   input  logic [N_RAILS-1:0] rail_in,
   input  logic               force_hi,
   output logic [N_RAILS-1:0] rail_out
);
   generate
      if (N_RAILS < 1) begin : g_bad_rails
         $error("N_RAILS must be at least 1");
      end
      for (genvar g = 0; g < N_RAILS; g++) begin : g_rail
         assign rail_out[g] = rail_in[g] | force_hi;
      end
   endgenerate
endmodule

// File: rtl/e1_los_monitor.sv
`timescale 1ns/1ps
module e1_los_monitor
   import e1_los_pkg::*;
#(
   parameter int unsigned SET_ZEROS   = 128,
   parameter int unsigned CLEAR_ONES  = 64,
   parameter int unsigned WINDOW_BITS = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic rail_pos_in,
   input  logic rail_neg_in,
   output logic los_o,
   output logic rail_pos_o,
   output logic rail_neg_o
);
   rail_pair_t                rails_in;
   logic [RAIL_COUNT-1:0]     rails_vec_in;
   logic [RAIL_COUNT-1:0]     rails_vec_out;
   logic                      mark;
   logic                      run_hit;
   logic                      win_clear;
   logic                      los_q;

   assign rails_in     = '{pos: rail_pos_in, neg: rail_neg_in};
   assign rails_vec_in = rails_in;
   assign mark         = is_mark(rails_in);

   e1_los_zero_run #(
      .SET_ZEROS (SET_ZEROS)
   ) u_zero_run (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (bit_en),
      .mark    (mark),
      .hold    (los_q),
      .run_hit (run_hit)
   );

   e1_los_density_window #(
      .CLEAR_ONES  (CLEAR_ONES),
      .WINDOW_BITS (WINDOW_BITS)
   ) u_window (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (bit_en),
      .mark      (mark),
      .arm       (los_q),
      .win_clear (win_clear)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         los_q <= 1'b0;
      end else if (bit_en) begin
         if (los_q && win_clear) begin
            los_q <= 1'b0;
         end else if (!los_q && run_hit) begin
            los_q <= 1'b1;
         end
      end
   end

   e1_los_rail_gate #(
      .N_RAILS (RAIL_COUNT)
   ) u_gate (
      .rail_in  (rails_vec_in),
      .force_hi (los_q),
      .rail_out (rails_vec_out)
   );

   assign los_o      = los_q;
   assign rail_pos_o = rails_vec_out[1];
   assign rail_neg_o = rails_vec_out[0];
endmodule

// File: rtl/e1_los_checker.sv
`timescale 1ns/1ps
module e1_los_checker #(
   parameter int unsigned SET_ZEROS = 128
) (
   input logic clk,
   input logic rst_n,
   input logic bit_en,
   input logic rail_pos_in,
   input logic rail_neg_in,
   input logic los_o,
   input logic rail_pos_o,
   input logic rail_neg_o
);
   logic mark;
   int unsigned zrun;

   assign mark = rail_pos_in | rail_neg_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zrun <= 0;
      end else if (bit_en) begin
         if (mark) zrun <= 0;
         else if (zrun < SET_ZEROS) zrun <= zrun + 1;
      end
   end

   p_rails_forced_r4: assert property (@(posedge clk) disable iff (!rst_n)
      los_o |-> (rail_pos_o && rail_neg_o));

   p_pass_through_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !los_o |-> (rail_pos_o == rail_pos_in && rail_neg_o == rail_neg_in));

   p_enable_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(los_o));

   p_mark_no_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && mark && !los_o) |=> !los_o);

   p_zero_no_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !mark && los_o) |=> los_o);

   p_set_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(los_o) |-> (zrun >= SET_ZEROS));
endmodule

bind e1_los_monitor e1_los_checker #(.SET_ZEROS(SET_ZEROS)) u_los_checker (.*);

// File: tb/test_e1_los_monitor.sv
`timescale 1ns/1ps
module test_e1_los_monitor;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ben = 1'b0;
   logic rp = 1'b0;
   logic rn = 1'b0;
   logic los_o, rail_pos_o, rail_neg_o;

   int checks = 0;
   int errors = 0;
   string phase = "R1";
   bit done = 0;

   int m_los = 0, m_zrun = 0, m_open = 0, m_bits = 0, m_ones = 0;

   always #5 clk = ~clk;

   e1_los_monitor i_e1_los_monitor (
      .clk(clk), .rst_n(rst_n), .bit_en(ben),
      .rail_pos_in(rp), .rail_neg_in(rn),
      .los_o(los_o), .rail_pos_o(rail_pos_o), .rail_neg_o(rail_neg_o));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model, compared every cycle
   always @(posedge clk) begin
      if (!rst_n) begin
         m_los = 0; m_zrun = 0; m_open = 0; m_bits = 0; m_ones = 0;
      end else if (ben) begin
         int mk;
         mk = (rp | rn) ? 1 : 0;
         if (m_los == 0) begin
            m_zrun = mk ? 0 : ((m_zrun < 128) ? m_zrun + 1 : 128);
            if (m_zrun >= 128) begin m_los = 1; m_open = 0; end
         end else begin
            if (m_open == 0) begin
               if (mk) begin m_open = 1; m_bits = 1; m_ones = 1; end
            end else begin
               m_bits++; m_ones += mk;
            end
            if (m_open && m_ones >= 64) begin m_los = 0; m_zrun = 0; m_open = 0; end
            else if (m_open && m_bits >= 512) m_open = 0;
         end
      end
      #2;
      if (rst_n && !done) begin
         int ep, en;
         ep = m_los ? 1 : int'(rp);
         en = m_los ? 1 : int'(rn);
         check(los_o == m_los[0], {phase, " model los"}, los_o, m_los);
         check(rail_pos_o == ep[0] && rail_neg_o == en[0], {phase, " model rails"},
               {rail_pos_o, rail_neg_o}, {ep[0], en[0]});
      end
   end

   task automatic send(input logic p, input logic n, input logic e);
      @(negedge clk);
      rp = p; rn = n; ben = e;
      @(posedge clk);
      #3;
   endtask

   task automatic zeros(input int k);
      for (int i = 0; i < k; i++) send(1'b0, 1'b0, 1'b1);
   endtask

   task automatic marks(input int k);
      for (int i = 0; i < k; i++) send(i[0], ~i[0], 1'b1);
   endtask

   task automatic los_is(input int exp, input string tag);
      check(los_o == exp[0], tag, los_o, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #3;
      los_is(0, "R1 reset state");
      send(1'b1, 1'b0, 1'b1);
      check(rail_pos_o == 1'b1 && rail_neg_o == 1'b0, "R5 pass through", {rail_pos_o, rail_neg_o}, 2);

      phase = "R3";
      zeros(127);                los_is(0, "R3 127 zeros");
      send(1'b0, 1'b1, 1'b1);
      zeros(127);                los_is(0, "R3 run reset by one");
      phase = "R2";
      zeros(1);                  los_is(1, "R2 128th zero");
      phase = "R3";
      zeros(400);                los_is(1, "R3 saturated run");
      check(rail_pos_o && rail_neg_o, "R4 forced high", {rail_pos_o, rail_neg_o}, 3);

      // R7: window with 63 ones closes, counts discarded
      phase = "R7";
      send(1'b1, 1'b0, 1'b1);
      for (int i = 1; i < 512; i++) begin
         if (i % 8 == 0 && i <= 496) send(1'b0, 1'b1, 1'b1);
         else send(1'b0, 1'b0, 1'b1);
      end
      los_is(1, "R7 63 ones in window");
      zeros(50);
      marks(63);                 los_is(1, "R7 fresh window 63");
      phase = "R6";
      marks(1);                  los_is(0, "R6 64th one clears");

      phase = "R9";
      zeros(127);                los_is(0, "R9 run restarted");
      zeros(1);                  los_is(1, "R2 set again");

      // R6 boundary: 64th one on 512th bit
      phase = "R6";
      send(1'b1, 1'b0, 1'b1);
      zeros(448);
      marks(62);                 los_is(1, "R6 63 ones before last bit");
      marks(1);                  los_is(0, "R6 64th on bit 512");

      phase = "R7";
      zeros(128);                los_is(1, "R2 set third time");
      send(1'b1, 1'b0, 1'b1);
      zeros(449);
      marks(62);                 los_is(1, "R7 window closed short");
      send(1'b1, 1'b1, 1'b1);    los_is(1, "R7 one after close");
      zeros(600);

      phase = "R8";
      for (int i = 0; i < 100; i++) send(1'b1, 1'b1, 1'b0);
      los_is(1, "R8 disabled ones ignored");
      marks(63);                 los_is(1, "R8 63 enabled ones");
      marks(1);                  los_is(0, "R8 64th enabled one");
      zeros(127);
      for (int i = 0; i < 20; i++) send(1'b0, 1'b0, 1'b0);
      los_is(0, "R8 disabled zeros ignored");
      zeros(1);                  los_is(1, "R8 128th enabled zero");

      phase = "R6/R7 random";
      for (int i = 0; i < 6000; i++) begin
         int dens;
         dens = (i < 3000) ? 12 : 5;
         send(($urandom % dens) == 0, ($urandom % dens) == 1, ($urandom % 4) != 0);
         if (i == 3000) begin
            phase = "R2/R3 random";
            zeros(200);
         end
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule